// File: doc/BRIEF.md
# Processor-side interrupt acknowledge and completion unit

This unit sits between the interrupt distributor and one processor. The distributor offers one candidate each cycle: an ID, a priority and, for software-generated IDs, the number of the processor that raised it. The unit decides whether that candidate may reach the processor. It drives a single interrupt line and holds the per-processor state that software reaches through a small 32-bit register bus.

Software turns signalling on with an enable bit and sets a priority threshold. When the line is high, software reads the acknowledge register. That read returns the ID and moves the interrupt into the active set. When the handler is done, software writes the same ID to the completion register, which releases it. A handler loop reads the acknowledge register until it returns an ID outside the valid range. When nothing can be delivered the read therefore returns the all-ones spurious ID, and that read changes nothing. One-cycle pulses on the acknowledge and completion outputs tell the distributor which ID was taken and which one was finished.

Top module: `cpu_if_ack_eoi`

## Requirements
- R1: After reset the enable bit is 0, the threshold is 0x00, no ID is active, and irq_o, ack_o, eoi_o and bus_rvalid_o are all low.
- R2: In the same cycle, irq_o is high exactly when all of the following hold: enable is 1, cand_valid_i is 1, cand_id_i is at most 510, that ID is not active, and cand_prio_i is below the threshold.
- R3: Register word 0 holds the enable in bit 0 and reads back. While enable is 0, irq_o stays low and an acknowledge read returns the spurious ID.
- R4: Register word 1 holds the priority threshold in bits 7:0 and reads back. The comparison is strict, so a candidate whose priority equals the threshold is not signalled.
- R5: A read of word 2 while irq_o is high returns cand_src_i in bits 12:10 and cand_id_i in bits 9:0, with all other bits 0. The cycle after the read, ack_o pulses with ack_id_o equal to that ID, and the ID becomes active.
- R6: A read of word 2 while irq_o is low returns 1023 and changes no state.
- R7: An active ID is never signalled or returned by an acknowledge read until it is completed.
- R8: A write to word 3 takes the ID from bits 9:0 and ignores the upper bits. If that ID is active, it is released, and the next cycle eoi_o pulses with eoi_id_o equal to the ID.
- R9: A completion write of an ID that is not active, including 1023, has no effect and produces no eoi_o pulse.
- R10: Every read gives bus_rvalid_o high in the cycle after the request. Word 3 reads as 0, and a write to word 2 has no effect.
- R11: Candidate IDs from 511 to 1023 are never signalled. ID 510 is signalled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | The distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_src_i | input | 3 | Requesting processor of a software-generated ID |
| cand_prio_i | input | 8 | Candidate priority, where a lower value is more urgent |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read |
| irq_o | output | 1 | Interrupt line to the processor |
| ack_o | output | 1 | Pulse: an ID was acknowledged |
| ack_id_o | output | 10 | ID that was acknowledged |
| eoi_o | output | 1 | Pulse: an ID was completed |
| eoi_id_o | output | 10 | ID that was completed |

## Verification
The candidate is swept across several cases: priorities just below and exactly at the threshold, IDs at 510, 511 and 600, and software-generated IDs that carry a source field. These cases separate a strict comparison from a non-strict one and show whether the range limit is enforced. Overlapping service of three IDs, completed in a different order from the one in which they were acknowledged, shows that the active set tracks each ID on its own. Completions of wrong IDs and of the spurious ID, a disabled interface, and a long pseudo-random mix of accesses check that nothing else changes state. A reference model is compared with the design in every cycle.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } cif_reg_e;
endpackage

// File: rtl/cif_cfg_regs.sv
module cif_cfg_regs #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_pmask_i,
  input  logic [31:0]       wdata_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] pmask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      pmask_o <= '0;
    end else begin
      if (wr_ctrl_i)  en_o    <= wdata_i[0];
      if (wr_pmask_i) pmask_o <= wdata_i[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/cif_active_set.sv
module cif_active_set #(
  parameter int unsigned ID_W    = 10,
  parameter int unsigned NUM_IDS = 511
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [ID_W-1:0] set_id_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] clr_id_i,
  input  logic [ID_W-1:0] query_id_i,
  output logic            query_hit_o,
  output logic            clr_hit_o
);
  localparam int unsigned SPACE = 1 << ID_W;

  logic [SPACE-1:0] act_q;

  // flops only for implemented IDs; the rest of the ID space reads as idle
  for (genvar i = 0; i < SPACE; i++) begin : g_bit
    if (i < NUM_IDS) begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                      act_q[i] <= 1'b0;
        else if (set_i && set_id_i == ID_W'(i))           act_q[i] <= 1'b1;
        else if (clr_i && clr_id_i == ID_W'(i))           act_q[i] <= 1'b0;
      end
    end else begin : g_tie
      assign act_q[i] = 1'b0;
    end
  end

  assign query_hit_o = act_q[query_id_i];
  assign clr_hit_o   = act_q[clr_id_i];
endmodule

// File: rtl/cif_present.sv
module cif_present #(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned MAX_ID = 510
) (
  input  logic              en_i,
  input  logic [PRIO_W-1:0] pmask_i,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              cand_active_i,
  output logic              present_o
);
  localparam logic [ID_W-1:0] MAX_ID_L = ID_W'(MAX_ID);

  logic in_range, below_mask;

  assign in_range   = cand_id_i <= MAX_ID_L;
  assign below_mask = cand_prio_i < pmask_i;
  assign present_o  = en_i & cand_valid_i & in_range & ~cand_active_i & below_mask;
endmodule

// File: rtl/cpu_if_ack_eoi.sv
module cpu_if_ack_eoi #(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned SRC_W  = 3,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned MAX_ID = 510
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cand_valid_i,
  input  logic [ID_W-1:0]           cand_id_i,
  input  logic [SRC_W-1:0]          cand_src_i,
  input  logic [PRIO_W-1:0]         cand_prio_i,
  input  logic                      bus_valid_i,
  input  logic                      bus_write_i,
  input  logic [cif_pkg::REG_AW-1:0] bus_addr_i,
  input  logic [cif_pkg::BUS_DW-1:0] bus_wdata_i,
  output logic [cif_pkg::BUS_DW-1:0] bus_rdata_o,
  output logic                      bus_rvalid_o,
  output logic                      irq_o,
  output logic                      ack_o,
  output logic [ID_W-1:0]           ack_id_o,
  output logic                      eoi_o,
  output logic [ID_W-1:0]           eoi_id_o
);
  import cif_pkg::*;

  localparam int unsigned    NUM_IDS = MAX_ID + 1;
  localparam int unsigned    PAD_W   = BUS_DW - ID_W - SRC_W;
  localparam logic [ID_W-1:0] SPUR_ID = '1;

  cif_reg_e          sel;
  logic              rd_req, wr_req, ack_rd, eoi_wr;
  logic              en;
  logic [PRIO_W-1:0] pmask;
  logic              cand_active, clr_hit, present, take, release_id;
  logic [ID_W-1:0]   eoi_id;
  logic [BUS_DW-1:0] rd_mux;

  assign sel        = cif_reg_e'(bus_addr_i);
  assign rd_req     = bus_valid_i & ~bus_write_i;
  assign wr_req     = bus_valid_i & bus_write_i;
  assign ack_rd     = rd_req & (sel == REG_ACK);
  assign eoi_wr     = wr_req & (sel == REG_EOI);
  assign eoi_id     = bus_wdata_i[ID_W-1:0];
  assign take       = ack_rd & present;
  assign release_id = eoi_wr & clr_hit;

  cif_cfg_regs #(.PRIO_W(PRIO_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_req & (sel == REG_CTRL)),
    .wr_pmask_i (wr_req & (sel == REG_PMASK)),
    .wdata_i    (bus_wdata_i),
    .en_o       (en),
    .pmask_o    (pmask)
  );

  cif_active_set #(.ID_W(ID_W), .NUM_IDS(NUM_IDS)) u_act (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (take),
    .set_id_i    (cand_id_i),
    .clr_i       (release_id),
    .clr_id_i    (eoi_id),
    .query_id_i  (cand_id_i),
    .query_hit_o (cand_active),
    .clr_hit_o   (clr_hit)
  );

  cif_present #(.ID_W(ID_W), .PRIO_W(PRIO_W), .MAX_ID(MAX_ID)) u_pres (
    .en_i          (en),
    .pmask_i       (pmask),
    .cand_valid_i  (cand_valid_i),
    .cand_id_i     (cand_id_i),
    .cand_prio_i   (cand_prio_i),
    .cand_active_i (cand_active),
    .present_o     (present)
  );

  assign irq_o = present;

  always_comb begin
    unique case (sel)
      REG_CTRL:  rd_mux = BUS_DW'(en);
      REG_PMASK: rd_mux = BUS_DW'(pmask);
      REG_ACK:   rd_mux = present ? {{PAD_W{1'b0}}, cand_src_i, cand_id_i}
                                  : BUS_DW'(SPUR_ID);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
      ack_o        <= 1'b0;
      ack_id_o     <= '0;
      eoi_o        <= 1'b0;
      eoi_id_o     <= '0;
    end else begin
      bus_rvalid_o <= rd_req;
      ack_o        <= take;
      eoi_o        <= release_id;
      if (rd_req)     bus_rdata_o <= rd_mux;
      if (take)       ack_id_o    <= cand_id_i;
      if (release_id) eoi_id_o    <= eoi_id;
    end
  end
endmodule

// File: rtl/cpu_if_ack_eoi_chk.sv
module cpu_if_ack_eoi_chk #(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned MAX_ID = 510
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cand_valid_i,
  input logic [ID_W-1:0]   cand_id_i,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [1:0]        bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic              irq_o,
  input logic              ack_o,
  input logic [ID_W-1:0]   ack_id_o,
  input logic              eoi_o,
  input logic [ID_W-1:0]   eoi_id_o,
  input logic              en,
  input logic [PRIO_W-1:0] pmask
);
  localparam logic [ID_W-1:0] MAX_ID_L = ID_W'(MAX_ID);

  AST_IRQ_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cand_valid_i); // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en); // R3
  AST_IRQ_BELOW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_prio_i < pmask)); // R4
  AST_ACK_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(bus_valid_i && !bus_write_i && bus_addr_i == 2'd2)); // R5
  AST_ACK_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_id_o <= MAX_ID_L); // R5
  AST_SPURIOUS_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rvalid_o && bus_rdata_o[ID_W-1:0] == '1) |-> !ack_o); // R6
  AST_EOI_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> $past(bus_valid_i && bus_write_i && bus_addr_i == 2'd3)); // R8
  AST_EOI_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> eoi_id_o <= MAX_ID_L); // R9
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o); // R10
  AST_IRQ_ID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cand_id_i <= MAX_ID_L); // R11
endmodule

bind cpu_if_ack_eoi cpu_if_ack_eoi_chk #(
  .ID_W(ID_W), .PRIO_W(PRIO_W), .MAX_ID(MAX_ID)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cand_valid_i (cand_valid_i),
  .cand_id_i    (cand_id_i),
  .cand_prio_i  (cand_prio_i),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .ack_o        (ack_o),
  .ack_id_o     (ack_id_o),
  .eoi_o        (eoi_o),
  .eoi_id_o     (eoi_id_o),
  .en           (en),
  .pmask        (pmask)
);

// File: tb/cpu_if_ack_eoi_bench.sv
`timescale 1ns/1ps
module cpu_if_ack_eoi_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cv = 1'b0;
  logic [9:0]  cid = '0;
  logic [2:0]  csrc = '0;
  logic [7:0]  cpr = '0;
  logic        bv = 1'b0;
  logic        bw = 1'b0;
  logic [1:0]  ba = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        rvalid, irq, ack, eoi;
  logic [9:0]  ack_id, eoi_id;

  always #5 clk = ~clk;

  cpu_if_ack_eoi u_cpu_if_ack_eoi (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cv), .cand_id_i(cid), .cand_src_i(csrc), .cand_prio_i(cpr),
    .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(wd),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq),
    .ack_o(ack), .ack_id_o(ack_id), .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model
  bit m_act [0:1023];
  int m_en, m_pm, m_rdata, m_ack_id, m_eoi_id;
  bit m_rvalid, m_ack, m_eoi;

  function automatic bit m_present();
    return m_en != 0 && cv && int'(cid) <= 510 && !m_act[cid] && int'(cpr) < m_pm;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit p;
    int id;
    #1;
    p = m_present();
    chk("R2 irq", 32'(irq), 32'(p));
    @(posedge clk);
    m_rvalid = 0; m_ack = 0; m_eoi = 0;
    if (bv && !bw) begin
      m_rvalid = 1;
      case (ba)
        2'd0: m_rdata = m_en;
        2'd1: m_rdata = m_pm;
        2'd2: if (p) begin
                m_rdata = (int'(csrc) << 10) | int'(cid);
                m_act[cid] = 1; m_ack = 1; m_ack_id = cid;
              end else m_rdata = 1023;
        default: m_rdata = 0;
      endcase
    end else if (bv && bw) begin
      case (ba)
        2'd0: m_en = int'(wd[0]);
        2'd1: m_pm = int'(wd[7:0]);
        2'd3: begin
          id = int'(wd[9:0]);
          if (id <= 510 && m_act[id]) begin
            m_act[id] = 0; m_eoi = 1; m_eoi_id = id;
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R10 rvalid", 32'(rvalid), 32'(m_rvalid));
    if (m_rvalid) chk("R5 rdata", rdata, m_rdata);
    chk("R5 ack", 32'(ack), 32'(m_ack));
    if (m_ack) chk("R5 ack_id", 32'(ack_id), m_ack_id);
    chk("R8 eoi", 32'(eoi), 32'(m_eoi));
    if (m_eoi) chk("R8 eoi_id", 32'(eoi_id), m_eoi_id);
  endtask

  task automatic idle();
    bv = 0; step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bv = 1; bw = 0; ba = a; step(); d = rdata; bv = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    bv = 1; bw = 1; ba = a; wd = v; step(); bv = 0; bw = 0;
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [2:0] s,
                      input logic [7:0] pr);
    cv = v; cid = id; csrc = s; cpr = pr;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 1024; i++) m_act[i] = 0;
    m_en = 0; m_pm = 0; m_rdata = 0; m_ack_id = 0; m_eoi_id = 0;
    m_rvalid = 0; m_ack = 0; m_eoi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ack", 32'(ack), 0);
    chk("R1 eoi", 32'(eoi), 0);
    chk("R1 rvalid", 32'(rvalid), 0);
    @(negedge clk);
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 pmask", d, 0);

    // disabled interface
    cand(1, 10'd40, 0, 8'h20); idle();
    chk("R3 irq while disabled", 32'(irq), 0);
    rd(2'd2, d); chk("R6 spurious", d, 1023);

    wr(2'd1, 32'hF0); wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R3 ctrl readback", d, 1);
    rd(2'd1, d); chk("R4 pmask readback", d, 32'hF0);
    #1 chk("R2 irq on", 32'(irq), 1);
    cpr = 8'hF0; #1 chk("R4 equal prio", 32'(irq), 0);
    cpr = 8'hEF; #1 chk("R4 below prio", 32'(irq), 1);
    @(negedge clk);

    // acknowledge and completion
    rd(2'd2, d); chk("R5 ack id", d, 40);
    #1 chk("R7 active not shown", 32'(irq), 0);
    @(negedge clk);
    rd(2'd2, d); chk("R7 active not returned", d, 1023);
    wr(2'd3, 32'd41); chk("R9 wrong eoi", 32'(eoi), 0);
    wr(2'd3, 32'd1023); chk("R9 spurious eoi", 32'(eoi), 0);
    #1 chk("R9 still active", 32'(irq), 0);
    @(negedge clk);
    wr(2'd3, 32'd40);
    chk("R8 eoi pulse", 32'(eoi), 1);
    chk("R8 eoi id", 32'(eoi_id), 40);
    #1 chk("R8 released", 32'(irq), 1);
    @(negedge clk);

    // write to acknowledge word, read of completion word
    wr(2'd2, 32'h55);
    rd(2'd3, d); chk("R10 eoi word reads 0", d, 0);
    rd(2'd2, d); chk("R10 ack write ignored", d, 40);
    wr(2'd3, 32'd40);

    // software-generated ID with source field, full word completion
    cand(1, 10'd3, 3'd5, 8'h10);
    rd(2'd2, d); chk("R5 sgi word", d, 32'h1403);
    wr(2'd3, 32'h1403); chk("R8 sgi eoi id", 32'(eoi_id), 3);

    // ID range
    cand(1, 10'd600, 0, 8'h00); #1 chk("R11 id 600", 32'(irq), 0);
    @(negedge clk);
    rd(2'd2, d); chk("R11 ack 600", d, 1023);
    cand(1, 10'd511, 0, 8'h00); #1 chk("R11 id 511", 32'(irq), 0);
    cand(1, 10'd510, 0, 8'h00); #1 chk("R11 id 510", 32'(irq), 1);
    @(negedge clk);
    rd(2'd2, d); chk("R11 ack 510", d, 510);
    wr(2'd3, 32'd510);

    // overlapping service, out-of-order completion
    cand(1, 10'd100, 0, 8'h30); rd(2'd2, d); chk("R5 ack 100", d, 100);
    cand(1, 10'd200, 0, 8'h30); rd(2'd2, d); chk("R5 ack 200", d, 200);
    cand(1, 10'd300, 0, 8'h30); rd(2'd2, d); chk("R5 ack 300", d, 300);
    wr(2'd3, 32'd200);
    cand(1, 10'd100, 0, 8'h30); #1 chk("R7 100 held", 32'(irq), 0);
    cand(1, 10'd200, 0, 8'h30); #1 chk("R7 200 free", 32'(irq), 1);
    @(negedge clk);
    wr(2'd3, 32'd300); wr(2'd3, 32'd100);

    // disable again
    wr(2'd0, 32'h0);
    #1 chk("R3 irq off", 32'(irq), 0);
    @(negedge clk);
    rd(2'd2, d); chk("R3 ack while off", d, 1023);
    wr(2'd0, 32'h1);

    // pseudo-random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      cand(r[0] | r[1], {2'b00, r[9:2]} + ((r[10]) ? 10'd400 : 10'd0), r[13:11], r[21:14]);
      case (r[24:22])
        3'd0, 3'd1: rd(2'd2, d);
        3'd2: wr(2'd3, {22'd0, (r[25] ? cid : 10'(r[31:26]))});
        3'd3: wr(2'd1, {24'd0, r[31:24]});
        3'd4: rd(2'(r[26:25]), d);
        3'd5: if (r[31:28] == 4'h0) wr(2'd0, {31'd0, r[27]}); else idle();
        default: idle();
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule